// File: doc/BRIEF.md
# Linked Group Storage Allocator

This block keeps variable-length data in a chain of fixed-size groups of words. Every group is eight 64-bit words. The first seven words hold data. The eighth word holds the address of the next group in the chain. Free groups are kept on a singly linked list that runs through those same link words, with a head register that points at the first free group. The word store sits inside the block.

A client sends one command at a time over a valid/ready request channel. Assign-group takes the group at the head of the free list and returns the address of its first word. Store-and-assign writes a data word at the address supplied and returns the address where the next word of the same chain belongs. When the write fills the last data slot of a group, the block takes another group from the free list and writes that group's address into the full group's link word. It then returns the first word of the new group. A read command returns any stored word, so chains can be walked from outside the block.

There is one page of 32 groups. The page is not set up at reset. The first allocation that finds the free list empty threads all 32 groups onto the list and then completes. Once every group has been handed out, a later allocation reports an error instead of returning an address.

Top module: `lga_alloc_top`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and busy are both 0.
- R2: Assign-group (req_op 2'b00) responds with the first word (address bits [2:0] = 0) of the group at the head of the free list. On a freshly set-up page, successive allocations return the groups in ascending address order: 0, 8, 16, and so on.
- R3: An allocation that finds the free list empty while the page is not yet set up first spends at least 32 cycles with busy high. During that time it links every group's word 7 to the base of the following group, and the final group's word 7 is all ones. It then takes group 0.
- R4: Store-and-assign (req_op 2'b01) to an address whose bits [2:0] are 0 to 5 writes req_data there and responds with that address plus 1. No allocation takes place and busy stays low.
- R5: Store-and-assign to an address whose bits [2:0] are 6 writes the data, allocates a group, and writes the new group's base address (zero-extended) into word 7 of the full group. It responds with the new group's base address and holds busy high during the allocation.
- R6: Any group that has just been allocated has word 7 set to all ones, the end-of-chain value.
- R7: Store-and-assign to an address whose bits [2:0] are 7 writes nothing. It responds with rsp_error 1 and rsp_addr 0.
- R8: After all 32 groups have been allocated, every further allocation responds with rsp_error 1 and rsp_addr 0. A store to slot 6 still writes its data word, and the full group's word 7 stays all ones.
- R9: A read (req_op 2'b10) responds with the word stored at req_addr on rsp_data. The reserved code 2'b11 responds with rsp_error 1.
- R10: Only one command is in flight at a time. From acceptance until the response has been given, req_ready is 0. busy is never 1 while req_ready is 1. rsp_valid is high for exactly one cycle per accepted command and never without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Block idle and able to accept a command |
| req_op | input | 2 | 00 assign-group, 01 store-and-assign, 10 read, 11 reserved |
| req_addr | input | 8 | Word address for store and read |
| req_data | input | 64 | Data word for store |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 8 | Returned address (0 on error or read) |
| rsp_data | output | 64 | Word returned by a read |
| rsp_error | output | 1 | Command failed |
| busy | output | 1 | Allocate, page set-up or link sequence in progress |

## Verification
A damaged head pointer or a badly threaded link word does not show at once. It shows at the next allocation, which returns a group out of ascending order or one that is already in use, or it shows when a read walks a link word. For this reason, the bench reads link words back right after each allocation, while the chain is still short. A slot-decode error shows within one response: a store returns the wrong next address, or it allocates when it should not, and that is also visible as a busy pulse that should not be there. Exhausting the page checks the end-of-list detection, which otherwise only shows on the 33rd allocation.

// File: rtl/lga_pkg.sv
package lga_pkg;

  typedef enum logic [1:0] {
    OP_ASSIGN = 2'b00,
    OP_STORE  = 2'b01,
    OP_READ   = 2'b10,
    OP_RSVD   = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EXEC,
    S_ALLOC,
    S_INIT,
    S_LINK,
    S_RESP
  } state_e;

endpackage

// File: rtl/lga_word_store.sv
module lga_word_store #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];

  // R6 / R5: a link word only ever receives end-of-chain or a group base
  a_r6_link_format: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (&wr_addr[SLOT_W-1:0])) |->
      ((&wr_data) || ((wr_data[SLOT_W-1:0] == '0) && (wr_data[DATA_W-1:ADDR_W] == '0))));

endmodule

// File: rtl/lga_free_list.sv
module lga_free_list #(
  parameter int DATA_W      = 64,
  parameter int SLOT_W      = 3,
  parameter int GRP_W       = 5,
  parameter int ADDR_W      = 8,
  parameter int PAGE_GROUPS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_step,
  input  logic              pop,
  input  logic [DATA_W-1:0] link_rd,
  output logic [GRP_W-1:0]  head_grp,
  output logic              head_empty,
  output logic              page_loaded,
  output logic [GRP_W-1:0]  init_grp,
  output logic              init_last
);

  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(PAGE_GROUPS - 1);

  logic [GRP_W-1:0] init_cnt;
  logic             link_is_null;

  assign init_grp     = init_cnt;
  assign init_last    = (init_cnt == LAST_GRP);
  assign link_is_null = &link_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt    <= '0;
      head_grp    <= '0;
      head_empty  <= 1'b1;
      page_loaded <= 1'b0;
    end else if (init_step) begin
      init_cnt <= init_cnt + GRP_W'(1);
      if (init_last) begin
        head_grp    <= '0;
        head_empty  <= 1'b0;
        page_loaded <= 1'b1;
      end
    end else if (pop) begin
      if (link_is_null) head_empty <= 1'b1;
      else              head_grp   <= link_rd[ADDR_W-1:SLOT_W];
    end
  end

  // R10: the controller never pops an empty list
  a_r10_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !head_empty);

  // R3: the single page is set up at most once
  a_r3_init_once: assert property (@(posedge clk) disable iff (!rst_n)
    init_step |-> !page_loaded);

  // R2: a link followed by the free list points at a group boundary
  a_r2_link_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !link_is_null) |-> (link_rd[SLOT_W-1:0] == '0));

endmodule

// File: rtl/lga_ctrl.sv
module lga_ctrl
  import lga_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int SLOT_W      = 3,
  parameter int GRP_W       = 5,
  parameter int ADDR_W      = 8,
  parameter int PAGE_GROUPS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_error,
  output logic              busy,
  input  logic [GRP_W-1:0]  head_grp,
  input  logic              head_empty,
  input  logic              page_loaded,
  input  logic [GRP_W-1:0]  init_grp,
  input  logic              init_last,
  output logic              init_step,
  output logic              pop,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_a_addr,
  output logic [ADDR_W-1:0] rd_b_addr,
  input  logic [DATA_W-1:0] rd_b_data
);

  localparam logic [SLOT_W-1:0] LINK_SLOT = '1;
  localparam logic [SLOT_W-1:0] LAST_DATA = LINK_SLOT - SLOT_W'(1);
  localparam logic [GRP_W-1:0]  LAST_GRP  = GRP_W'(PAGE_GROUPS - 1);

  function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[SLOT_W-1:0];
  endfunction

  function automatic logic [GRP_W-1:0] grp_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SLOT_W];
  endfunction

  function automatic logic [ADDR_W-1:0] base_of(input logic [GRP_W-1:0] g);
    return {g, {SLOT_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] link_of(input logic [GRP_W-1:0] g);
    return {g, LINK_SLOT};
  endfunction

  function automatic logic [DATA_W-1:0] link_word(input logic [GRP_W-1:0] g);
    return DATA_W'(base_of(g));
  endfunction

  function automatic logic [DATA_W-1:0] init_link(input logic [GRP_W-1:0] g);
    return (g == LAST_GRP) ? '1 : link_word(g + GRP_W'(1));
  endfunction

  state_e            state;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [GRP_W-1:0]  new_grp_q;
  logic [ADDR_W-1:0] rsp_addr_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_err_q;

  logic exec_store_wr;
  logic at_link_slot;
  logic at_last_data;

  assign at_link_slot  = (slot_of(addr_q) == LINK_SLOT);
  assign at_last_data  = (slot_of(addr_q) == LAST_DATA);
  assign exec_store_wr = (state == S_EXEC) && (op_q == OP_STORE) && !at_link_slot;

  assign init_step = (state == S_INIT);
  assign pop       = (state == S_ALLOC) && !head_empty;
  assign rd_a_addr = link_of(head_grp);
  assign rd_b_addr = addr_q;

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = addr_q;
    wr_data = data_q;
    if (exec_store_wr) begin
      wr_en = 1'b1;
    end else if (init_step) begin
      wr_en   = 1'b1;
      wr_addr = link_of(init_grp);
      wr_data = init_link(init_grp);
    end else if (pop) begin
      wr_en   = 1'b1;
      wr_addr = link_of(head_grp);
      wr_data = '1;
    end else if (state == S_LINK) begin
      wr_en   = 1'b1;
      wr_addr = link_of(grp_of(addr_q));
      wr_data = link_word(new_grp_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      op_q       <= OP_ASSIGN;
      addr_q     <= '0;
      data_q     <= '0;
      new_grp_q  <= '0;
      rsp_addr_q <= '0;
      rsp_data_q <= '0;
      rsp_err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_q       <= op_e'(req_op);
          addr_q     <= req_addr;
          data_q     <= req_data;
          rsp_addr_q <= '0;
          rsp_data_q <= '0;
          rsp_err_q  <= 1'b0;
          state      <= S_EXEC;
        end
        S_EXEC: begin
          case (op_q)
            OP_ASSIGN: state <= S_ALLOC;
            OP_STORE: begin
              if (at_link_slot) begin
                rsp_err_q <= 1'b1;
                state     <= S_RESP;
              end else if (at_last_data) begin
                state <= S_ALLOC;
              end else begin
                rsp_addr_q <= addr_q + ADDR_W'(1);
                state      <= S_RESP;
              end
            end
            OP_READ: begin
              rsp_data_q <= rd_b_data;
              state      <= S_RESP;
            end
            default: begin
              rsp_err_q <= 1'b1;
              state     <= S_RESP;
            end
          endcase
        end
        S_ALLOC: begin
          if (head_empty) begin
            if (!page_loaded) begin
              state <= S_INIT;
            end else begin
              rsp_err_q <= 1'b1;
              state     <= S_RESP;
            end
          end else begin
            new_grp_q  <= head_grp;
            rsp_addr_q <= base_of(head_grp);
            state      <= (op_q == OP_STORE) ? S_LINK : S_RESP;
          end
        end
        S_INIT: if (init_last) state <= S_ALLOC;
        S_LINK: state <= S_RESP;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign busy      = (state == S_ALLOC) || (state == S_INIT) || (state == S_LINK);
  assign rsp_addr  = rsp_addr_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_error = rsp_err_q;

  // R10: a response is followed by the idle state
  a_r10_rsp_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

  // R2: successful allocations return a group's first word
  a_r2_assign_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_error && op_q == OP_ASSIGN) |-> (slot_of(rsp_addr) == '0));

  // R5: a returned write address never lands on a link word
  a_r5_not_link: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_error) |-> (slot_of(rsp_addr) != LINK_SLOT));

  // R4: a plain store returns the following address
  a_r4_store_next: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_STORE && !rsp_error && slot_of(addr_q) < LAST_DATA)
      |-> (rsp_addr == addr_q + ADDR_W'(1)));

  // R7: a store aimed at a link word writes nothing
  a_r7_no_link_store: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && op_q == OP_STORE && at_link_slot) |-> !wr_en);

endmodule

// File: rtl/lga_alloc_top.sv
module lga_alloc_top #(
  parameter int DATA_W      = 64,
  parameter int GROUP_WORDS = 8,
  parameter int PAGE_GROUPS = 32,
  localparam int SLOT_W     = $clog2(GROUP_WORDS),
  localparam int GRP_W      = $clog2(PAGE_GROUPS),
  localparam int ADDR_W     = SLOT_W + GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_error,
  output logic              busy
);

  logic [GRP_W-1:0]  head_grp;
  logic              head_empty;
  logic              page_loaded;
  logic [GRP_W-1:0]  init_grp;
  logic              init_last;
  logic              init_step;
  logic              pop;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [ADDR_W-1:0] rd_a_addr;
  logic [DATA_W-1:0] rd_a_data;
  logic [ADDR_W-1:0] rd_b_addr;
  logic [DATA_W-1:0] rd_b_data;

  lga_word_store #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
  );

  lga_free_list #(
    .DATA_W(DATA_W), .SLOT_W(SLOT_W), .GRP_W(GRP_W),
    .ADDR_W(ADDR_W), .PAGE_GROUPS(PAGE_GROUPS)
  ) u_free (
    .clk(clk), .rst_n(rst_n),
    .init_step(init_step), .pop(pop), .link_rd(rd_a_data),
    .head_grp(head_grp), .head_empty(head_empty), .page_loaded(page_loaded),
    .init_grp(init_grp), .init_last(init_last)
  );

  lga_ctrl #(
    .DATA_W(DATA_W), .SLOT_W(SLOT_W), .GRP_W(GRP_W),
    .ADDR_W(ADDR_W), .PAGE_GROUPS(PAGE_GROUPS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data), .rsp_error(rsp_error), .busy(busy),
    .head_grp(head_grp), .head_empty(head_empty), .page_loaded(page_loaded),
    .init_grp(init_grp), .init_last(init_last), .init_step(init_step), .pop(pop),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
  );

endmodule

// File: tb/lga_alloc_top_test.sv
module lga_alloc_top_test;

  localparam int AW = 8;
  localparam int DW = 64;
  localparam logic [DW-1:0] NULLW = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          rsp_valid;
  logic [AW-1:0] rsp_addr;
  logic [DW-1:0] rsp_data;
  logic          rsp_error;
  logic          busy;

  lga_alloc_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .rsp_error(rsp_error), .busy(busy)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int mon_fail = 0;
  int cycles = 0;
  bit pending = 0;

  // behavioural model
  int            free_q[$];
  logic [DW-1:0] mdl_mem [int];
  bit            loaded = 0;

  // last response
  logic [AW-1:0] got_addr;
  logic [DW-1:0] got_data;
  logic          got_err;
  bit            saw_busy;
  int            lat;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mdl_alloc(output int g, output bit ok);
    if (free_q.size() == 0 && !loaded) begin
      for (int i = 0; i < 32; i++) begin
        free_q.push_back(i * 8);
        mdl_mem[i * 8 + 7] = (i == 31) ? NULLW : DW'(64'((i + 1) * 8));
      end
      loaded = 1;
    end
    if (free_q.size() == 0) begin
      ok = 0; g = 0;
    end else begin
      g = free_q.pop_front();
      mdl_mem[g + 7] = NULLW;
      ok = 1;
    end
  endtask

  task automatic mdl_exec(input logic [1:0] op, input int a, input logic [DW-1:0] d,
                          output int ea, output logic [DW-1:0] ed, output bit ee);
    int g; bit ok;
    ea = 0; ed = '0; ee = 0;
    case (op)
      2'b00: begin
        mdl_alloc(g, ok);
        if (ok) ea = g; else ee = 1;
      end
      2'b01: begin
        if ((a % 8) == 7) ee = 1;
        else begin
          mdl_mem[a] = d;
          if ((a % 8) < 6) ea = a + 1;
          else begin
            mdl_alloc(g, ok);
            if (ok) begin
              mdl_mem[(a / 8) * 8 + 7] = DW'(64'(g));
              ea = g;
            end else ee = 1;
          end
        end
      end
      2'b10: ed = mdl_mem.exists(a) ? mdl_mem[a] : '0;
      default: ee = 1;
    endcase
  endtask

  // called at a negedge
  task automatic run_cmd(input logic [1:0] op, input int a, input logic [DW-1:0] d, input string tag);
    int ea; logic [DW-1:0] ed; bit ee;
    mdl_exec(op, a, d, ea, ed, ee);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_data = d;
    @(negedge clk);
    req_valid = 1'b0; pending = 1; lat = 1; saw_busy = 0;
    while (!rsp_valid && lat < 500) begin
      if (busy) saw_busy = 1;
      @(negedge clk); lat++;
    end
    got_addr = rsp_addr; got_data = rsp_data; got_err = rsp_error;
    check(rsp_valid, {tag, " R10 response seen"}, DW'(rsp_valid), 1);
    check(got_err == ee, {tag, " error flag"}, DW'(got_err), DW'(ee));
    if (op == 2'b10) check(got_data == ed, {tag, " read data"}, got_data, ed);
    else check(got_addr == AW'(ea), {tag, " address"}, DW'(got_addr), DW'(ea));
    @(negedge clk);
    pending = 0;
  endtask

  // handshake monitor, R10
  always @(posedge clk) begin
    if (rst_n) begin
      if (rsp_valid && !pending) mon_fail++;
      if (req_ready && pending)  mon_fail++;
      if (busy && req_ready)     mon_fail++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(req_ready == 1'b1, "R1 ready after reset", DW'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 no response after reset", DW'(rsp_valid), 0);
    check(busy == 1'b0, "R1 not busy after reset", DW'(busy), 0);

    // R3 first allocation sets up the page
    run_cmd(2'b00, 0, '0, "R3 first assign");
    check(saw_busy, "R3 busy during set-up", DW'(saw_busy), 1);
    check(lat > 32, "R3 set-up length", DW'(lat), 33);
    run_cmd(2'b10, 15, '0, "R3 group1 link threads to 16");
    run_cmd(2'b10, 255, '0, "R3 last group link null");
    run_cmd(2'b10, 7, '0, "R6 allocated link null");

    // R4 plain stores
    for (int s = 0; s < 6; s++) begin
      run_cmd(2'b01, s, 64'hA5A5_0000_0000_0000 | 64'(s * 64'h1111), "R4 store slot");
      check(!saw_busy, "R4 no busy on plain store", DW'(saw_busy), 0);
    end
    // R5 last data slot chains a new group
    run_cmd(2'b01, 6, 64'hDEAD_BEEF_0123_4567, "R5 store last slot");
    check(saw_busy, "R5 busy during link", DW'(saw_busy), 1);
    run_cmd(2'b10, 7, '0, "R5 full group link word");
    run_cmd(2'b10, 15, '0, "R6 new group link null");
    for (int s = 0; s < 7; s++) run_cmd(2'b10, s, '0, "R9 read back data");

    // R7 store at link slot
    run_cmd(2'b01, 7, 64'h1234, "R7 store to link slot");
    run_cmd(2'b10, 7, '0, "R7 link word unchanged");
    // R9 reserved op
    run_cmd(2'b11, 3, '0, "R9 reserved op");

    // R2 ascending allocation, second chain
    run_cmd(2'b00, 0, '0, "R2 assign next group");
    run_cmd(2'b01, 16 + 6, 64'hFFFF_0000_FFFF_0000, "R5 second chain link");
    run_cmd(2'b10, 23, '0, "R5 second chain link word");
    run_cmd(2'b01, 24, 64'h0, "R4 store zero data");
    run_cmd(2'b10, 24, '0, "R9 read zero data");

    // R8 exhaust the page
    for (int k = 0; k < 29; k++) run_cmd(2'b00, 0, '0, "R8 assign until empty");
    check(got_err, "R8 final assign errors", DW'(got_err), 1);
    run_cmd(2'b01, 248 + 6, 64'hCAFE_F00D_CAFE_F00D, "R8 store last slot no group");
    run_cmd(2'b10, 254, '0, "R8 data still written");
    run_cmd(2'b10, 255, '0, "R8 link stays null");
    run_cmd(2'b01, 248 + 3, 64'h77, "R4 store after exhaustion");

    check(mon_fail == 0, "R10 handshake monitor", DW'(mon_fail), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule